// File: doc/BRIEF.md
# Sample FIFO with DMA Request and Interrupt Status

This block buffers 16-bit two's complement samples from a converter in a first-in first-out store and hands them to the host in two ways. Software can read them one by one through a data register, or a DMA controller can take them through a request/acknowledge pair. A status register gathers the FIFO flags, a terminal-count flag raised by the DMA side, two condition inputs from elsewhere in the converter (calibration busy, acquisition finished), the pending-interrupt state and a 2-bit board identification code. A write-only control register enables DMA and picks demand or single transfers, and enables the interrupt sources.

Samples arrive on a valid/ready stream. Ready is high while capture is enabled and the FIFO has room. A converter cannot be stalled, so a valid sample offered while capture is enabled and ready is low (the FIFO is full) is dropped and recorded as an overflow. While capture is disabled, ready is low and offered samples are ignored without any overflow. Samples pass through unchanged; any sign conversion is done by the consumer.

The register port uses a 2-bit address: 0 is the data register (read removes the oldest sample), 1 reads status and writes control, 2 is the FIFO reset (any write), 3 is the terminal-count clear (any write). Read data is combinational in the cycle of the read strobe. DEPTH must be a power of two.

Top module: `smpfifo_ctrl`

## Requirements
- R1: After reset the FIFO is empty, the control register is zero, the terminal-count and overflow flags are clear, irq and dma_req are low, and status reads as the board code in bits [9:8] with all other bits zero.
- R2: A sample is stored on a clock edge where cap_en, smp_valid and smp_ready are all high; smp_ready equals cap_en and not full; with cap_en low an offered sample is neither stored nor counted as overflow.
- R3: A sample offered while cap_en is high and the FIFO is full is dropped and sets status bit 3 (overflow), which stays set across reads until a FIFO reset write.
- R4: A read of address 0 returns the oldest stored sample bit for bit and removes it, in arrival order; a read of an empty FIFO returns zero and removes nothing.
- R5: Status (read, address 1): bit 0 FIFO not empty, bit 3 overflow, bit 4 acq_done input, bit 5 cal_busy input, bit 6 irq output, bit 7 terminal-count flag, bits [9:8] board_id input, all other bits zero.
- R6: Control (write, address 1) keeps only bit 3 DMA enable, bit 8 FIFO interrupt enable, bit 9 half-full select, bit 11 terminal-count interrupt enable and bit 12 demand mode; all other written bits have no effect.
- R7: Any write to address 2 empties the FIFO and clears overflow; a sample offered in that same cycle is discarded.
- R8: In demand mode (bits 3 and 12 set) dma_req is high whenever the FIFO is not empty; every cycle with dma_ack high while dma_req is high removes the sample shown on dma_data.
- R9: In single mode (bit 3 set, bit 12 clear) dma_req rises one cycle after data is present, falls in the cycle after an accepted acknowledge, and rises again one cycle later if data remains.
- R10: dma_ack while dma_req is low removes nothing and cannot set the terminal-count flag.
- R11: An accepted acknowledge with dma_tc high sets status bit 7; any write to address 3 clears it, except that a new terminal count in the same cycle wins.
- R12: irq is high when bit 8 is set and the FIFO condition holds (not empty with bit 9 clear, at least DEPTH/2 entries with bit 9 set), or when bit 11 is set and the terminal-count flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable from the acquisition sequencer |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | FIFO accepts a sample |
| smp_data | input | 16 | Converter sample, two's complement |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |
| dma_tc | input | 1 | DMA terminal count, valid with dma_ack |
| dma_data | output | 16 | Oldest sample, taken on acknowledge |
| cal_busy | input | 1 | Offset calibration in progress |
| acq_done | input | 1 | End of acquisition |
| board_id | input | 2 | Board identification code |
| irq | output | 1 | Interrupt request |

## Verification
A wrong fill count shows in the same cycle as a false not-empty bit, a half-full interrupt at the wrong depth or an out-of-order sample on the data register or dma_data. A lost or stuck single-mode request state shows as dma_req staying high in the cycle after an acknowledge or never returning, visible one cycle after the edge. A terminal-count or overflow flag with the wrong set/clear priority appears in status bit 7 or 3 on the next status read and, for terminal count, on irq at once when its enable is set.

// File: rtl/smpfifo_pkg.sv
package smpfifo_pkg;
  // status bit positions (read at address 1)
  localparam int ST_NEMPTY = 0;
  localparam int ST_OVF    = 3;
  localparam int ST_ACQ    = 4;
  localparam int ST_CAL    = 5;
  localparam int ST_IRQ    = 6;
  localparam int ST_TC     = 7;
  localparam int ST_ID     = 8;
  // control bit positions (written at address 1)
  localparam int CT_DMAEN  = 3;
  localparam int CT_FIE    = 8;
  localparam int CT_HALF   = 9;
  localparam int CT_TCIE   = 11;
  localparam int CT_DEMAND = 12;

  typedef enum logic [1:0] {
    A_DATA  = 2'd0,
    A_STAT  = 2'd1,
    A_FLUSH = 2'd2,
    A_TCCLR = 2'd3
  } addr_e;

  typedef struct packed {
    logic dma_en;
    logic fifo_ie;
    logic half_sel;
    logic tc_ie;
    logic demand;
  } ctrl_t;
endpackage

// File: rtl/smpfifo_store.sv
module smpfifo_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rptr];

  wire do_push = push && !full && !clr;
  wire do_pop  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/smpfifo_dma.sv
module smpfifo_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dma_en,
  input  logic demand,
  input  logic not_empty,
  input  logic ack,
  input  logic tc_in,
  input  logic tc_clr,
  output logic req,
  output logic take,
  output logic tc_flag
);
  logic single_q;

  assign req  = dma_en && not_empty && (demand || single_q);
  assign take = req && ack;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || take) single_q <= 1'b0;
    else                       single_q <= dma_en && !demand && not_empty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              tc_flag <= 1'b0;
    else if (take && tc_in)  tc_flag <= 1'b1;
    else if (tc_clr)         tc_flag <= 1'b0;
  end

  p_single_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !demand) |=> (demand || !req));
  p_tc_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tc_in) |=> tc_flag);
  p_tc_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_clr && !(take && tc_in)) |=> !tc_flag);
  p_no_ack_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_flag && !req && !tc_clr) |=> !tc_flag);
endmodule

// File: rtl/smpfifo_irq.sv
module smpfifo_irq #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          fifo_ie,
  input  logic          half_sel,
  input  logic          tc_ie,
  input  logic          tc_flag,
  output logic          irq
);
  logic fifo_cond;

  always_comb begin
    if (half_sel) fifo_cond = (cnt >= CW'(DEPTH / 2));
    else          fifo_cond = (cnt != '0);
  end

  assign irq = (fifo_ie && fifo_cond) || (tc_ie && tc_flag);

  p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fifo_ie || tc_ie));
  p_irq_tc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_ie && tc_flag) |-> irq);
endmodule

// File: rtl/smpfifo_ctrl.sv
module smpfifo_ctrl
  import smpfifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_data,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          dma_req,
  input  logic          dma_ack,
  input  logic          dma_tc,
  output logic [DW-1:0] dma_data,
  input  logic          cal_busy,
  input  logic          acq_done,
  input  logic [1:0]    board_id,
  output logic          irq
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] head;
  logic [CW-1:0] cnt;
  logic          empty, full, ovf_q, take, tc_flag;
  logic          unused_wbits;

  wire wr_ctl  = reg_wr && (reg_addr == A_STAT);
  wire flush   = reg_wr && (reg_addr == A_FLUSH);
  wire tc_clr  = reg_wr && (reg_addr == A_TCCLR);
  wire rd_pop  = reg_rd && (reg_addr == A_DATA) && !empty;
  wire lost    = cap_en && smp_valid && full;

  assign smp_ready    = cap_en && !full;
  assign dma_data     = head;
  assign unused_wbits = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctl) begin
      ctrl_q.dma_en   <= reg_wdata[CT_DMAEN];
      ctrl_q.fifo_ie  <= reg_wdata[CT_FIE];
      ctrl_q.half_sel <= reg_wdata[CT_HALF];
      ctrl_q.tc_ie    <= reg_wdata[CT_TCIE];
      ctrl_q.demand   <= reg_wdata[CT_DEMAND];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) ovf_q <= 1'b0;
    else if (lost)       ovf_q <= 1'b1;
  end

  smpfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push(cap_en && smp_valid), .wdata(smp_data),
    .pop(take || rd_pop), .head(head), .cnt(cnt),
    .empty(empty), .full(full)
  );

  smpfifo_dma u_dma (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .dma_en(ctrl_q.dma_en), .demand(ctrl_q.demand), .not_empty(!empty),
    .ack(dma_ack), .tc_in(dma_tc), .tc_clr(tc_clr),
    .req(dma_req), .take(take), .tc_flag(tc_flag)
  );

  smpfifo_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .cnt(cnt),
    .fifo_ie(ctrl_q.fifo_ie), .half_sel(ctrl_q.half_sel),
    .tc_ie(ctrl_q.tc_ie), .tc_flag(tc_flag), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (addr_e'(reg_addr))
        A_DATA: if (!empty) reg_rdata = 16'(head);
        A_STAT: begin
          reg_rdata[ST_NEMPTY]      = !empty;
          reg_rdata[ST_OVF]         = ovf_q;
          reg_rdata[ST_ACQ]         = acq_done;
          reg_rdata[ST_CAL]         = cal_busy;
          reg_rdata[ST_IRQ]         = irq;
          reg_rdata[ST_TC]          = tc_flag;
          reg_rdata[ST_ID +: 2]     = board_id;
        end
        default: reg_rdata = '0;
      endcase
    end
  end

  p_lost_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !flush) |=> ovf_q);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !flush) |=> ovf_q);
  p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !smp_ready);
endmodule

// File: tb/sim_smpfifo_ctrl.sv
module sim_smpfifo_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_en = 1'b1, smp_valid = 1'b0, smp_ready;
  logic [15:0] smp_data = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic dma_req, dma_ack = 1'b0, dma_tc = 1'b0;
  logic [15:0] dma_data;
  logic cal_busy = 1'b0, acq_done = 1'b0;
  logic [1:0] board_id = 2'b10;
  logic irq;
  int errors = 0, checks = 0;
  logic [15:0] st;

  always #10 clk = ~clk;

  smpfifo_ctrl u0 (.*);

  typedef struct packed {
    logic [15:0] ctrl;
    logic [7:0]  n;
    logic        irq;
    logic        req;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{16'h0000, 8'd3, 1'b0, 1'b0},
    '{16'h0100, 8'd0, 1'b0, 1'b0},
    '{16'h0100, 8'd1, 1'b1, 1'b0},
    '{16'h0300, 8'd7, 1'b0, 1'b0},
    '{16'h0300, 8'd8, 1'b1, 1'b0},
    '{16'h0008, 8'd1, 1'b0, 1'b1},
    '{16'h1008, 8'd2, 1'b0, 1'b1},
    '{16'h1008, 8'd0, 1'b0, 1'b0},
    '{16'h0800, 8'd5, 1'b0, 1'b0}
  };

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick;
    reg_wr = 1'b0;
  endtask

  task automatic push(logic [15:0] v);
    smp_valid = 1'b1; smp_data = v;
    tick;
    smp_valid = 1'b0;
  endtask

  task automatic rd_data(string tag, logic [15:0] exp);
    reg_rd = 1'b1; reg_addr = 2'd0; #1;
    check(tag, reg_rdata, exp);
    tick;
    reg_rd = 1'b0;
  endtask

  task automatic get_status(output logic [15:0] v);
    reg_rd = 1'b1; reg_addr = 2'd1; #1;
    v = reg_rdata;
    reg_rd = 1'b0; #1;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R1 reset state
    get_status(st);
    check("R1 status", st, 16'h0200);
    check("R1 irq/req", {14'b0, irq, dma_req}, 16'h0);
    check("R1 ready", {15'b0, smp_ready}, 16'h1);

    // table walk: R12 interrupt conditions, R8/R9 request level
    foreach (VEC[i]) begin
      wr_reg(2'd2, 16'h0);
      wr_reg(2'd1, VEC[i].ctrl);
      for (int k = 0; k < int'(VEC[i].n); k++) push(16'(k + 16'h100));
      tick; tick;
      check($sformatf("R12 vec%0d irq", i), {15'b0, irq}, {15'b0, VEC[i].irq});
      check($sformatf("R8 vec%0d req", i), {15'b0, dma_req}, {15'b0, VEC[i].req});
      get_status(st);
      check($sformatf("R5 vec%0d nempty", i), {15'b0, st[0]}, {15'b0, VEC[i].n != 0});
    end

    // R4 order and empty read
    wr_reg(2'd2, 16'h0);
    wr_reg(2'd1, 16'h0);
    push(16'h8000); push(16'h7FFF); push(16'h1234);
    rd_data("R4 first", 16'h8000);
    rd_data("R4 second", 16'h7FFF);
    rd_data("R4 third", 16'h1234);
    rd_data("R4 empty read", 16'h0000);
    get_status(st);
    check("R4 empty status", st, 16'h0200);

    // R2 capture disabled
    cap_en = 1'b0; #1;
    check("R2 ready low", {15'b0, smp_ready}, 16'h0);
    push(16'h5555);
    get_status(st);
    check("R2 ignored", st, 16'h0200);
    cap_en = 1'b1;

    // R3 overflow and R7 reset
    for (int k = 0; k < 16; k++) push(16'(k * 3));
    check("R2 full ready", {15'b0, smp_ready}, 16'h0);
    get_status(st);
    check("R3 no ovf yet", st, 16'h0201);
    push(16'hDEAD);
    get_status(st);
    check("R3 ovf set", st, 16'h0209);
    rd_data("R3 oldest kept", 16'h0000);
    get_status(st);
    check("R3 ovf sticky", st, 16'h0209);
    smp_valid = 1'b1; smp_data = 16'hBEEF;
    wr_reg(2'd2, 16'h0);
    smp_valid = 1'b0;
    get_status(st);
    check("R7 flush", st, 16'h0200);

    // R5 passthrough bits
    cal_busy = 1'b1; acq_done = 1'b1;
    get_status(st);
    check("R5 cal/acq", st, 16'h0230);
    cal_busy = 1'b0; acq_done = 1'b0;

    // R6 other control bits ignored
    wr_reg(2'd1, 16'hE4F7);
    push(16'h0042);
    tick; tick;
    check("R6 ignored bits", {14'b0, irq, dma_req}, 16'h0);
    wr_reg(2'd2, 16'h0);

    // R8 demand mode, R11 terminal count
    wr_reg(2'd1, 16'h1008);
    push(16'hA001); push(16'hA002); push(16'hA003);
    check("R8 req", {15'b0, dma_req}, 16'h1);
    check("R8 data1", dma_data, 16'hA001);
    dma_ack = 1'b1;
    tick;
    check("R8 data2", dma_data, 16'hA002);
    tick;
    check("R8 data3", dma_data, 16'hA003);
    dma_tc = 1'b1;
    tick;
    dma_ack = 1'b0; dma_tc = 1'b0;
    check("R8 drained req", {15'b0, dma_req}, 16'h0);
    get_status(st);
    check("R11 tc set", st, 16'h0280);
    wr_reg(2'd1, 16'h1808);
    get_status(st);
    check("R12 tc irq", {st[15:0]}, 16'h02C0);
    check("R12 irq pin", {15'b0, irq}, 16'h1);
    wr_reg(2'd3, 16'h0);
    get_status(st);
    check("R11 tc clear", st, 16'h0200);
    push(16'hB001);
    dma_ack = 1'b1; dma_tc = 1'b1;
    wr_reg(2'd3, 16'h0);
    dma_ack = 1'b0; dma_tc = 1'b0;
    get_status(st);
    check("R11 set wins", st, 16'h02C0);
    wr_reg(2'd3, 16'h0);

    // R10 ack without request
    wr_reg(2'd2, 16'h0);
    wr_reg(2'd1, 16'h0000);
    push(16'hC001);
    dma_ack = 1'b1; dma_tc = 1'b1;
    tick;
    dma_ack = 1'b0; dma_tc = 1'b0;
    get_status(st);
    check("R10 no effect", st, 16'h0201);
    rd_data("R10 data kept", 16'hC001);

    // R9 single mode
    wr_reg(2'd1, 16'h0008);
    push(16'hD001); push(16'hD002);
    tick;
    check("R9 req up", {15'b0, dma_req}, 16'h1);
    dma_ack = 1'b1;
    tick;
    dma_ack = 1'b0;
    check("R9 req drop", {15'b0, dma_req}, 16'h0);
    check("R9 next data", dma_data, 16'hD002);
    tick;
    check("R9 req again", {15'b0, dma_req}, 16'h1);
    dma_ack = 1'b1;
    tick;
    dma_ack = 1'b0;
    tick;
    check("R9 empty no req", {15'b0, dma_req}, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule